// File: doc/BRIEF.md
# Parallel Speculative Acceptance Sampler

This block judges every node of a draft token tree in one decision and returns the longest chain of accepted tokens that starts at the root. Each node carries two unsigned fixed-point probabilities: the verifier probability `q` and the draft probability `p`. Each node also has its own pseudo-random lane that holds a uniform fraction `u`. A node passes when `u < q/p`. The comparison is done without division, as `u·p < q`.

The per-node verdicts are then combined through the tree's parent links. A node counts only when the node itself and every one of its ancestors passed. Among the nodes that count, the deepest one wins, and a tie goes to the lowest index. The result is registered and announced with a one-cycle valid pulse. It gives the accepted path length, the index of the tip node and a bitmap of the nodes on that path.

Nodes are numbered 0..N-1, and node 0 is the root, which was committed earlier. A decision is requested by raising `start` for one cycle with the tree presented on the flat input buses. Resampling after a rejection is left to the surrounding logic.

Top module: `spec_accept_sampler`

## Requirements
- R1: After reset, `out_valid`, `path_len`, `last_node` and `path_map` are all 0. Random lane i holds the value i+1.
- R2: A node i≥1 passes when `p≠0` and `u·p < q·2^UW`, where `u` is lane i's value. Every node with `q ≥ p` and `p≠0` therefore passes, whatever its lane holds.
- R3: A node whose `p` is 0 never passes, whatever its `q`.
- R4: Each lane is a Galois LFSR that shifts left by one. When the bit shifted out is 1, the new value is XORed with `POLY` (default 8'h1D). Every lane advances exactly once per `start`. A `seed_load` writes lane i from `seed_flat[i*UW +: UW]`, and a zero seed is stored as 1.
- R5: The root is always valid and its parent field is ignored. Node i is valid only if it passes, its parent index (`parent_flat[i*IW +: IW]`) is below i, and that parent is valid. A node with a parent index ≥ i is never valid.
- R6: `path_len` is the largest depth among the valid nodes, where the root has depth 0. `last_node` is the lowest-indexed valid node of that depth.
- R7: `path_map` bit k is 1 exactly for the nodes that lie on the chain from `last_node` up to the root, with the root excluded. Its popcount therefore equals `path_len`.
- R8: When no child of the root is valid, the result is `path_len` 0, `last_node` 0 and `path_map` 0.
- R9: `out_valid` is high in exactly the cycle after each `start` cycle. The result outputs change only with that pulse and hold their value in between.
- R10: When `start` and `seed_load` arrive in the same cycle, the decision uses the lane values held before the load, and the lanes then take the seed instead of advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Loads all lanes from `seed_flat` |
| seed_flat | input | N*UW | Seed per lane, lane i at bits i*UW |
| start | input | 1 | Request one decision on the presented tree |
| q_flat | input | N*PW | Verifier probability per node |
| p_flat | input | N*PW | Draft probability per node |
| parent_flat | input | N*IW | Parent index per node |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| path_len | output | IW | Number of accepted nodes below the root |
| last_node | output | IW | Tip of the chosen path |
| path_map | output | N | Nodes on the chosen path |

## Verification
Every result is due exactly one clock edge after the `start` cycle, since the only register on the way is the output stage. The bench drives `start` on a falling edge, samples all outputs on the following falling edge, and samples once more a cycle later to confirm that the pulse has dropped and the result is held. The bench steps its own copy of the lanes at each decision, so that the random value behind every verdict is known cycle by cycle. A `seed_load` is applied only after that decision's expectation has been formed, which covers the same-cycle case.

// File: rtl/spec_accept_pkg.sv
package spec_accept_pkg;

  // Acceptance test without division: u/2^uw < q/p  <=>  u*p < q*2^uw
  function automatic logic lane_accepts(input logic [31:0] u, input logic [31:0] q,
                                        input logic [31:0] p, input int unsigned uw);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = {32'b0, u} * {32'b0, p};
    rhs = {32'b0, q} << uw;
    return (p != 32'b0) && (lhs < rhs);
  endfunction

  // One left-shifting Galois step of a w-bit generator
  function automatic logic [31:0] lfsr_next(input logic [31:0] s, input logic [31:0] poly,
                                            input int unsigned w);
    logic [31:0] mask;
    logic [31:0] r;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    r = (s << 1) ^ (s[w-1] ? poly : 32'h0);
    return r & mask;
  endfunction

  // A zero state would lock the generator, so it is replaced with 1
  function automatic logic [31:0] seed_fix(input logic [31:0] s, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    return ((s & mask) == 32'h0) ? 32'h1 : (s & mask);
  endfunction

endpackage

// File: rtl/sa_lanes.sv
module sa_lanes #(
  parameter int N = 8,
  parameter int UW = 8,
  parameter logic [31:0] POLY = 32'h1D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            load,
  input  logic [N*UW-1:0] seed_flat,
  output logic [N*UW-1:0] u_flat
);
  import spec_accept_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [UW-1:0] st;
    always_ff @(posedge clk) begin
      if (!rst_n)       st <= UW'(g + 1);
      else if (load)    st <= UW'(seed_fix(32'(seed_flat[g*UW +: UW]), UW));
      else if (advance) st <= UW'(lfsr_next(32'(st), POLY, UW));
    end
    assign u_flat[g*UW +: UW] = st;
  end
endmodule

// File: rtl/sa_judge.sv
module sa_judge #(
  parameter int N = 8,
  parameter int PW = 8,
  parameter int UW = 8
) (
  input  logic [N*UW-1:0] u_flat,
  input  logic [N*PW-1:0] q_flat,
  input  logic [N*PW-1:0] p_flat,
  output logic [N-1:0]    pass_vec
);
  import spec_accept_pkg::*;

  assign pass_vec[0] = 1'b1;  // root was committed earlier
  for (genvar g = 1; g < N; g++) begin : g_node
    assign pass_vec[g] = lane_accepts(32'(u_flat[g*UW +: UW]), 32'(q_flat[g*PW +: PW]),
                                      32'(p_flat[g*PW +: PW]), UW);
  end
endmodule

// File: rtl/sa_path.sv
module sa_path #(
  parameter int N = 8
) (
  input  logic [N-1:0]                 pass_vec,
  input  logic [N*$clog2(N)-1:0]       parent_flat,
  output logic [$clog2(N)-1:0]         best_len,
  output logic [$clog2(N)-1:0]         best_node,
  output logic [N-1:0]                 best_map
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] par   [N];
  logic [IW-1:0] depth [N];
  logic [N-1:0]  live;
  logic [IW-1:0] cur;

  always_comb begin
    for (int i = 0; i < N; i++) par[i] = parent_flat[i*IW +: IW];
    live     = '0;
    live[0]  = 1'b1;
    depth[0] = '0;
    for (int i = 1; i < N; i++) begin
      depth[i] = '0;
      if (pass_vec[i] && (par[i] < IW'(i)) && live[par[i]]) begin
        live[i]  = 1'b1;
        depth[i] = depth[par[i]] + 1'b1;
      end
    end
    best_len  = '0;
    best_node = '0;
    for (int i = 1; i < N; i++) begin
      if (live[i] && (depth[i] > best_len)) begin
        best_len  = depth[i];
        best_node = IW'(i);
      end
    end
    best_map = '0;
    cur      = best_node;
    for (int k = 0; k < N; k++) begin
      if (cur != '0) begin
        best_map[cur] = 1'b1;
        cur = par[cur];
      end
    end
  end
endmodule

// File: rtl/spec_accept_sampler.sv
module spec_accept_sampler #(
  parameter int N = 8,
  parameter int PW = 8,
  parameter int UW = 8,
  parameter logic [31:0] POLY = 32'h1D,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_load,
  input  logic [N*UW-1:0] seed_flat,
  input  logic            start,
  input  logic [N*PW-1:0] q_flat,
  input  logic [N*PW-1:0] p_flat,
  input  logic [N*IW-1:0] parent_flat,
  output logic            out_valid,
  output logic [IW-1:0]   path_len,
  output logic [IW-1:0]   last_node,
  output logic [N-1:0]    path_map
);
  logic [N*UW-1:0] u_flat;
  logic [N-1:0]    pass_vec;
  logic [IW-1:0]   nx_len;
  logic [IW-1:0]   nx_node;
  logic [N-1:0]    nx_map;

  sa_lanes #(.N(N), .UW(UW), .POLY(POLY)) u_lanes (
    .clk(clk), .rst_n(rst_n), .advance(start), .load(seed_load),
    .seed_flat(seed_flat), .u_flat(u_flat)
  );

  sa_judge #(.N(N), .PW(PW), .UW(UW)) u_judge (
    .u_flat(u_flat), .q_flat(q_flat), .p_flat(p_flat), .pass_vec(pass_vec)
  );

  sa_path #(.N(N)) u_path (
    .pass_vec(pass_vec), .parent_flat(parent_flat),
    .best_len(nx_len), .best_node(nx_node), .best_map(nx_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      path_len  <= '0;
      last_node <= '0;
      path_map  <= '0;
    end else begin
      out_valid <= start;
      if (start) begin
        path_len  <= nx_len;
        last_node <= nx_node;
        path_map  <= nx_map;
      end
    end
  end
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int N = 8,
  parameter int UW = 8,
  localparam int IW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            out_valid,
  input logic [IW-1:0]   path_len,
  input logic [IW-1:0]   last_node,
  input logic [N-1:0]    path_map,
  input logic [N*UW-1:0] lane_flat
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) start |=> out_valid);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(path_len) && $stable(last_node) && $stable(path_map)));
  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(path_map) == int'(path_len)));
  p_tip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && path_len != '0) |-> path_map[last_node]);
  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && path_len == '0) |-> (last_node == '0 && path_map == '0));
  p_root_r5: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !path_map[0]);

  for (genvar g = 0; g < N; g++) begin : g_lane_chk
    p_lane_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_flat[g*UW +: UW] != '0);
  end
endmodule

bind spec_accept_sampler sa_checker #(.N(N), .UW(UW)) u_sa_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid), .path_len(path_len),
  .last_node(last_node), .path_map(path_map), .lane_flat(u_flat)
);

// File: tb/test_spec_accept_sampler.sv
module test_spec_accept_sampler;
  localparam int N = 8;
  localparam int PW = 8;
  localparam int UW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic start = 1'b0;
  logic [N*UW-1:0] seed_flat;
  logic [N*PW-1:0] q_flat, p_flat;
  logic [N*IW-1:0] parent_flat;
  logic out_valid;
  logic [IW-1:0] path_len, last_node;
  logic [N-1:0] path_map;

  logic [7:0] q_m [N];
  logic [7:0] p_m [N];
  logic [2:0] par_m [N];
  logic [7:0] seed_m [N];
  logic [7:0] lane_m [N];

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      q_flat[i*PW +: PW]      = q_m[i];
      p_flat[i*PW +: PW]      = p_m[i];
      parent_flat[i*IW +: IW] = par_m[i];
      seed_flat[i*UW +: UW]   = seed_m[i];
    end
  end

  spec_accept_sampler #(.N(N), .PW(PW), .UW(UW)) i_spec_accept_sampler (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_flat(seed_flat), .start(start),
    .q_flat(q_flat), .p_flat(p_flat), .parent_flat(parent_flat), .out_valid(out_valid),
    .path_len(path_len), .last_node(last_node), .path_map(path_map)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] step8(input logic [7:0] s);
    return {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00);
  endfunction

  task automatic rnd(output int v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    v = int'(rs[30:0]);
  endtask

  // One decision: expectation from the bench lanes, optional same-cycle load
  task automatic decide(input string req, input bit with_load);
    int  e_len, e_node, e_map, lim;
    bit  ok [N];
    int  dep [N];
    int  cur;
    @(negedge clk);
    ok[0] = 1; dep[0] = 0;
    for (int i = 1; i < N; i++) begin
      bit pass;
      ok[i] = 0; dep[i] = 0;
      if (p_m[i] == 0) pass = 0;
      else begin
        lim  = (int'(q_m[i]) * 256 + int'(p_m[i]) - 1) / int'(p_m[i]);  // ceil(q*256/p)
        pass = int'(lane_m[i]) < lim;
      end
      if (pass && int'(par_m[i]) < i && ok[par_m[i]]) begin
        ok[i] = 1; dep[i] = dep[par_m[i]] + 1;
      end
    end
    e_len = 0; e_node = 0;
    for (int i = N - 1; i >= 1; i--)
      if (ok[i] && dep[i] >= e_len && dep[i] > 0) begin e_len = dep[i]; e_node = i; end
    e_map = 0; cur = e_node;
    while (cur != 0) begin e_map |= (1 << cur); cur = par_m[cur]; end
    start = 1'b1;
    seed_load = with_load;
    @(negedge clk);
    start = 1'b0;
    seed_load = 1'b0;
    for (int i = 0; i < N; i++)
      lane_m[i] = with_load ? ((seed_m[i] == 0) ? 8'd1 : seed_m[i]) : step8(lane_m[i]);
    chk("R9", "out_valid pulse", int'(out_valid), 1);
    chk(req, "path_len", int'(path_len), e_len);
    chk(req, "last_node", int'(last_node), e_node);
    chk("R7", "path_map", int'(path_map), e_map);
    @(negedge clk);
    chk("R9", "out_valid drop", int'(out_valid), 0);
    chk("R9", "path_len held", int'(path_len), e_len);
  endtask

  task automatic clear_tree();
    for (int i = 0; i < N; i++) begin q_m[i] = 8'd0; p_m[i] = 8'd0; par_m[i] = 3'd0; end
  endtask

  initial begin
    int v;
    clear_tree();
    for (int i = 0; i < N; i++) begin seed_m[i] = 8'd0; lane_m[i] = 8'(i + 1); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "path_len", int'(path_len), 0);
    chk("R1", "last_node", int'(last_node), 0);
    chk("R1", "path_map", int'(path_map), 0);

    // R1 / R4: reset lane values drive a marginal node (q=1,p=128 -> u<2)
    par_m[1] = 3'd0; q_m[1] = 8'd1; p_m[1] = 8'd128;
    decide("R1", 0);

    // R2: a chain with q>=p passes at every node
    for (int i = 1; i < N; i++) begin par_m[i] = 3'(i - 1); q_m[i] = 8'd9; p_m[i] = 8'd5; end
    decide("R2", 0);
    // R3: p=0 rejects even with the largest q
    for (int i = 1; i < N; i++) begin q_m[i] = 8'd255; p_m[i] = 8'd0; end
    decide("R3", 0);
    decide("R8", 0);
    // R6: two children of the root of equal depth, lowest index wins
    clear_tree();
    q_m[3] = 8'd7; p_m[3] = 8'd7; q_m[5] = 8'd7; p_m[5] = 8'd7;
    decide("R6", 0);
    // R5: accepted child under a rejected parent, and a forward parent link
    clear_tree();
    par_m[2] = 3'd1; q_m[2] = 8'd50; p_m[2] = 8'd50;
    par_m[4] = 3'd6; q_m[4] = 8'd50; p_m[4] = 8'd50;
    q_m[6] = 8'd50; p_m[6] = 8'd50;
    decide("R5", 0);

    // R4: explicit load including a zero seed, then a marginal node on that lane
    for (int i = 0; i < N; i++) seed_m[i] = 8'(17 * i + 3);
    seed_m[3] = 8'd0;
    clear_tree();
    q_m[3] = 8'd1; p_m[3] = 8'd128;
    decide("R4", 0);
    decide("R4", 1);   // R10: same-cycle load uses old lanes, then reloads
    decide("R4", 0);
    decide("R10", 0);

    // R2 / R5 / R6 sweep over many trees and probability mixes
    for (int t = 0; t < 1500; t++) begin
      for (int i = 1; i < N; i++) begin
        rnd(v);
        case (t % 4)
          0: par_m[i] = 3'(v % i);
          1: par_m[i] = 3'((v % 3 == 0) ? 0 : i - 1);
          2: par_m[i] = 3'(v % i);
          default: par_m[i] = 3'(v % N);
        endcase
        rnd(v); p_m[i] = 8'(v);
        rnd(v);
        if (t % 4 == 1) q_m[i] = 8'(int'(p_m[i]) + v % 40);
        else            q_m[i] = 8'(v);
        if (t % 4 == 2 && (v % 5 == 0)) p_m[i] = 8'd0;
      end
      if (t % 97 == 0) begin
        for (int i = 0; i < N; i++) begin rnd(v); seed_m[i] = 8'(v); end
        decide((t % 4 == 3) ? "R5" : "R10", 1);
      end else begin
        decide((t % 4 == 3) ? "R5" : ((t % 4 == 2) ? "R3" : "R6"), 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule